// File: doc/BRIEF.md
# Cascadable Serial Configuration Bit Reader

This block is the read side of a serial configuration store. It holds a bitstream in an internal bit array and sends it one bit per clock to a device that loads its configuration over a single serial data line. A power-on timer holds the block quiet after reset. While that timer runs, a ready pin is pulled low. Once the timer ends, the block drives stored bits whenever it is selected, enabled and in read mode.

Several blocks can be chained to form a longer stream. Each block's active-low cascade output feeds the next block's active-low select. When a block has sent the last bit of its array, it drops its cascade output and stops driving the data line. The next block then takes over the line on the following clock, with no gap and no overlap.

The read can start at the base of the array or at the base of any of several equal pages. A separate serial-enable pin selects programming mode, in which readout stops. Programming uses a simple bit-write port, which is accepted only in that mode.

The data line is modelled as a value plus an output-enable pin, so a shared line is formed by whichever block has its enable high. The stream has no valid/ready handshake. The receiver takes one bit on every clock while the block drives. To pause the stream, the receiver raises select or lowers serial-enable, which stops both the driver and the address counter in the same cycle.

Top module: `cfg_stream_rom`

## Requirements
- R1: While the block is enabled, `data_en` is 1 and `data_o` equals the stored bit at the current read address. Enabled means the power-on timer has ended, `rst_oe_n` is 1, `cs_n` is 0, `ser_en` is 1 and `casc_n` is 1. Each rising clock edge while enabled moves the read address up by one.
- R2: After `por_n` rises, `busy_pull` stays 1 for exactly POR_CYCLES (default 16) rising edges and then stays 0. `data_en` is 0 throughout that interval, whatever the other inputs are.
- R3: The read start address is captured on every edge while `rst_oe_n` is 0 or the power-on timer is running. It is 0 when `page_en` is 0, whatever `page_sel` holds. It is `page_sel` × (DEPTH/PAGES) when `page_en` is 1. With the defaults, `page_sel` is 2 bits and pages are 256 bits long.
- R4: The edge that consumes the bit at address DEPTH-1 drives `casc_n` to 0, and from that cycle on `data_en` is 0. Both stay that way until a reload.
- R5: While `rst_oe_n` is 0, `data_en` is 0. The edge seen with `rst_oe_n` at 0 reloads the start address and returns `casc_n` to 1.
- R6: While `cs_n` is 1, `data_en` is 0 and the read address holds. When `cs_n` returns to 0, the stream resumes with the bit that was next.
- R7: While `ser_en` is 0, `data_en` is 0 and the address holds. The write port stores `ld_bit` at `ld_addr` on an edge with `ld_en` at 1 only while `ser_en` is 0. A write attempted while `ser_en` is 1 leaves the array unchanged.
- R8: When two blocks are chained, with the first block's `casc_n` driving the second block's `cs_n`, exactly one of them drives the shared line on every cycle of the joined stream. The shared line carries the first block's bits from its start address up to DEPTH-1, followed at once by the second block's bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock; all state changes on its rising edge |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| cs_n | input | 1 | Chip select, active low |
| rst_oe_n | input | 1 | Active-low counter reload; releases the data driver when low |
| page_en | input | 1 | 1 selects a paged start address |
| page_sel | input | $clog2(PAGES) | Page index used when `page_en` is 1 |
| ser_en | input | 1 | 1 = read mode, 0 = programming mode |
| ld_en | input | 1 | Write strobe of the bit-write port |
| ld_addr | input | $clog2(DEPTH) | Write address |
| ld_bit | input | 1 | Bit to store |
| data_o | output | 1 | Serial data value |
| data_en | output | 1 | Data driver enable; 0 means high impedance |
| casc_n | output | 1 | Cascade output to the next block's `cs_n`, active low |
| busy_pull | output | 1 | 1 while the ready pin is pulled low (power-on timer running) |

## Verification
The assertions assume that `por_n` is the only asynchronous input and that every other input changes away from the rising clock edge. The bench meets this by driving all inputs on the falling edge. The assertions also assume that the start-address inputs hold their value once `rst_oe_n` has risen, because the address-step property takes the start as fixed during a stream. The bench changes `page_en` and `page_sel` only inside a reload window. Random pauses come only through `cs_n` or `ser_en`, never through `rst_oe_n`, so every pause must hold the address rather than reload it.

// File: rtl/cfgrom_pkg.sv
package cfgrom_pkg;
  function automatic int width_of(input int count);
    return (count > 1) ? $clog2(count) : 1;
  endfunction
endpackage

// File: rtl/cfgrom_por.sv
module cfgrom_por #(
  parameter int POR_CYCLES = 16
) (
  input  logic clk,
  input  logic por_n,
  output logic busy
);
  localparam int CW = cfgrom_pkg::width_of(POR_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(POR_CYCLES);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)             cnt <= '0;
    else if (cnt != LIMIT)  cnt <= cnt + CW'(1);
  end

  assign busy = (cnt != LIMIT);

  AST_POR_ONE_WAY: assert property (@(posedge clk) disable iff (!por_n)
    !busy |=> !busy); // R2
endmodule

// File: rtl/cfgrom_store.sv
module cfgrom_store #(
  parameter int DEPTH = 1024,
  parameter int AW    = 10
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic          wr_bit,
  input  logic [AW-1:0] rd_addr,
  output logic          rd_bit
);
  logic mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_bit;
  end

  assign rd_bit = mem[rd_addr];
endmodule

// File: rtl/cfgrom_addr.sv
module cfgrom_addr #(
  parameter int DEPTH = 1024,
  parameter int PAGES = 4,
  parameter int AW    = 10,
  parameter int PSW   = 2
) (
  input  logic           clk,
  input  logic           por_n,
  input  logic           reload,
  input  logic           page_en,
  input  logic [PSW-1:0] page_sel,
  input  logic           adv,
  output logic [AW-1:0]  addr,
  output logic           casc_n
);
  localparam int PAGE_BITS = DEPTH / PAGES;
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0] start;

  generate
    if (PAGES > 1) begin : g_paged
      assign start = page_en ? AW'(AW'(page_sel) * AW'(PAGE_BITS)) : '0;
    end else begin : g_flat
      logic unused_sel;
      assign unused_sel = page_en ^ (^page_sel);
      assign start = '0;
    end
  endgenerate

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      addr   <= '0;
      casc_n <= 1'b1;
    end else if (reload) begin
      addr   <= start;
      casc_n <= 1'b1;
    end else if (adv) begin
      if (addr == LAST) casc_n <= 1'b0;
      else              addr   <= addr + AW'(1);
    end
  end

  AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!por_n)
    (!adv && !reload) |=> $stable(addr)); // R6
  AST_RELOAD_CLEARS_CASC: assert property (@(posedge clk) disable iff (!por_n)
    reload |=> casc_n); // R5
  AST_CASC_STICKY: assert property (@(posedge clk) disable iff (!por_n)
    (!casc_n && !reload) |=> !casc_n); // R4
  AST_CASC_AT_END: assert property (@(posedge clk) disable iff (!por_n)
    $fell(casc_n) |-> (addr == LAST)); // R4
endmodule

// File: rtl/cfg_stream_rom.sv
module cfg_stream_rom #(
  parameter int DEPTH      = 1024,
  parameter int PAGES      = 4,
  parameter int POR_CYCLES = 16,
  localparam int AW  = cfgrom_pkg::width_of(DEPTH),
  localparam int PSW = cfgrom_pkg::width_of(PAGES)
) (
  input  logic           clk,
  input  logic           por_n,
  input  logic           cs_n,
  input  logic           rst_oe_n,
  input  logic           page_en,
  input  logic [PSW-1:0] page_sel,
  input  logic           ser_en,
  input  logic           ld_en,
  input  logic [AW-1:0]  ld_addr,
  input  logic           ld_bit,
  output logic           data_o,
  output logic           data_en,
  output logic           casc_n,
  output logic           busy_pull
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic          busy;
  logic [AW-1:0] addr;
  logic          reload;

  cfgrom_por #(.POR_CYCLES(POR_CYCLES)) u_por (
    .clk(clk), .por_n(por_n), .busy(busy)
  );

  assign reload  = busy | ~rst_oe_n;
  assign data_en = ~busy & rst_oe_n & ~cs_n & ser_en & casc_n;

  cfgrom_addr #(.DEPTH(DEPTH), .PAGES(PAGES), .AW(AW), .PSW(PSW)) u_addr (
    .clk(clk), .por_n(por_n), .reload(reload), .page_en(page_en),
    .page_sel(page_sel), .adv(data_en), .addr(addr), .casc_n(casc_n)
  );

  cfgrom_store #(.DEPTH(DEPTH), .AW(AW)) u_store (
    .clk(clk), .wr_en(ld_en & ~ser_en), .wr_addr(ld_addr), .wr_bit(ld_bit),
    .rd_addr(addr), .rd_bit(data_o)
  );

  assign busy_pull = busy;

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (!por_n)
    (data_en && addr != LAST) |=> (addr == $past(addr) + AW'(1))); // R1
  AST_QUIET_IN_PROG: assert property (@(posedge clk) disable iff (!por_n)
    (!ser_en && !reload) |=> $stable(addr)); // R7
endmodule

// File: tb/sim_cfg_stream_rom.sv
module sim_cfg_stream_rom;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 1024;
  localparam int PAGES = 4;
  localparam int PAGE_BITS = DEPTH / PAGES;
  localparam int POR_CYC = 16;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic por_n = 1'b0;
  logic cs_n0 = 1'b0, rst0 = 1'b1, rst1 = 1'b1, pe0 = 1'b0, pe1 = 1'b0;
  logic [1:0] ps0 = '0, ps1 = '0;
  logic ser0 = 1'b1, ser1 = 1'b1, ld_en = 1'b0, lb0 = 1'b0, lb1 = 1'b0;
  logic [9:0] ld_addr = '0;
  logic d0, e0, c0, b0, d1, e1, c1, b1;

  logic m0 [DEPTH];
  logic m1 [DEPTH];
  int total = 0, bad = 0;

  cfg_stream_rom u0 (.clk(clk), .por_n(por_n), .cs_n(cs_n0), .rst_oe_n(rst0),
    .page_en(pe0), .page_sel(ps0), .ser_en(ser0), .ld_en(ld_en), .ld_addr(ld_addr),
    .ld_bit(lb0), .data_o(d0), .data_en(e0), .casc_n(c0), .busy_pull(b0));
  cfg_stream_rom u1 (.clk(clk), .por_n(por_n), .cs_n(c0), .rst_oe_n(rst1),
    .page_en(pe1), .page_sel(ps1), .ser_en(ser1), .ld_en(ld_en), .ld_addr(ld_addr),
    .ld_bit(lb1), .data_o(d1), .data_en(e1), .casc_n(c1), .busy_pull(b1));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit exp_bit(input int start0, input int idx);
    int len0 = DEPTH - start0;
    return (idx < len0) ? m0[start0 + idx] : m1[idx - len0];
  endfunction

  // Reload both blocks; on return, rst is high at a falling edge.
  task automatic restart(input logic pe, input logic [1:0] ps);
    @(negedge clk);
    rst0 = 1'b0; rst1 = 1'b0; cs_n0 = 1'b0; ser0 = 1'b1; ser1 = 1'b1;
    pe0 = pe; ps0 = ps;
    #1;
    chk(e0 == 1'b0 && e1 == 1'b0, "R5 no drive in reload", int'(e0) + int'(e1), 0);
    @(negedge clk);
    #1;
    chk(c0 == 1'b1, "R5 casc high after reload", c0, 1);
    rst0 = 1'b1; rst1 = 1'b1;
  endtask

  // Stream the joined chain from start0 until idx reaches target, plus 3 cycles.
  task automatic run(input int start0, input int target);
    int len0 = DEPTH - start0;
    int L = len0 + DEPTH;
    int idx = 0;
    int post = 0;
    while (post < 3) begin
      bit st = ($urandom % 8) == 0;
      bit kind = $urandom % 2;
      int nd;
      bit line;
      if (idx < len0) begin
        cs_n0 = st & kind; ser0 = !(st & !kind); ser1 = 1'b1;
      end else begin
        cs_n0 = 1'b0; ser0 = 1'b1; ser1 = !st;
      end
      #1;
      nd = int'(e0) + int'(e1);
      line = e0 ? d0 : d1;
      if (idx >= L) begin
        chk(nd == 0, "R4 chain silent after end", nd, 0);
        chk(c1 == 1'b0, "R4 last casc low", c1, 0);
      end else if (st) begin
        chk(nd == 0, (idx < len0 && kind) ? "R6 cs pause" : "R7 ser pause", nd, 0);
      end else begin
        chk(nd == 1, "R8 one driver", nd, 1);
        chk(line == exp_bit(start0, idx), "R1 stream bit", line, exp_bit(start0, idx));
      end
      chk(c0 == (idx < len0), "R4 first casc", c0, int'(idx < len0));
      if (!st && idx < L) idx++;
      if (idx >= target) post++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    // Reset state
    #(CLK_PERIOD*2);
    @(negedge clk);
    chk(b0 == 1'b1, "R2 ready pulled in reset", b0, 1);
    chk(e0 == 1'b0, "R2 no drive in reset", e0, 0);
    chk(c0 == 1'b1, "R4 casc high in reset", c0, 1);
    por_n = 1'b1;
    for (int i = 0; i <= POR_CYC; i++) begin
      #1;
      chk(b0 == (i < POR_CYC), "R2 por length", b0, int'(i < POR_CYC));
      if (i < POR_CYC) chk(e0 == 1'b0, "R2 no drive during por", e0, 0);
      @(negedge clk);
    end
    // Load both arrays in programming mode
    ser0 = 1'b0; ser1 = 1'b0; rst0 = 1'b0; rst1 = 1'b0;
    for (int a = 0; a < DEPTH; a++) begin
      m0[a] = $urandom % 2; m1[a] = $urandom % 2;
      ld_en = 1'b1; ld_addr = 10'(a); lb0 = m0[a]; lb1 = m1[a];
      @(negedge clk);
    end
    ld_en = 1'b0;
    // Write attempt in read mode must be ignored
    ser0 = 1'b1; ser1 = 1'b1; rst0 = 1'b1; cs_n0 = 1'b1;
    ld_en = 1'b1; ld_addr = '0; lb0 = !m0[0];
    #1;
    chk(e0 == 1'b0, "R6 cs high no drive", e0, 0);
    @(negedge clk);
    ld_en = 1'b0;
    // Page select ignored when paging is off
    restart(1'b0, 2'd3);
    #1;
    chk(d0 == m0[0] && e0 == 1'b1, "R7 ignored write, R3 base start", d0, m0[0]);
    run(0, 2 * DEPTH);
    // Every page
    for (int p = PAGES - 1; p >= 0; p--) begin
      restart(1'b1, 2'(p));
      #1;
      chk(d0 == m0[p * PAGE_BITS], "R3 page start bit", d0, m0[p * PAGE_BITS]);
      run(p * PAGE_BITS, DEPTH - p * PAGE_BITS + 8);
      chk(c0 == 1'b0, "R4 casc low before reload", c0, 0);
    end
    restart(1'b1, 2'd1);
    chk(c0 == 1'b1, "R5 casc restored", c0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule